// File: doc/BRIEF.md
# Debug System-Bus Access Engine

This block sits inside a debug module and lets an external debugger read and write system memory while the processor keeps running. The debugger talks to it through three registers on the debug-register port: a control/status register, an address register and a data register. Bus accesses are not issued by a command. They start as side effects of register accesses: writing the data register, writing the address register, or reading the data register.

The engine drives one 32-bit memory master port. The port holds a request until the memory answers with a done pulse. With address auto-increment enabled, the address advances by 4 after every completed access, so a debugger can stream a block of words. It does this with repeated data writes, or with repeated data reads when read-on-data is set. Only word (32-bit) accesses go onto the bus.

The debug-register port is valid/ready. A request is accepted when `req_valid` and `req_ready` are both high. At most one response is outstanding. While `rsp_valid` is high and the host holds `rsp_ready` low, `req_ready` stays low and the response data is frozen, so the host applies back-pressure simply by not taking the response. The memory port is a held request: `bus_valid` and its qualifiers stay unchanged until `bus_done`.

Top module: `sba_engine`

## Requirements
- R1: After reset, the control register reads 0x20000404, the address and data registers read 0, `bus_valid` is low and `req_ready` is high. The fixed parts of the control value are: version 1 in bits [31:29], address width 32 in bits [11:5], and bit 2 set, meaning word access is supported.
- R2: `req_ready` equals not `rsp_valid`. `rsp_valid` rises in the cycle after a request is accepted. It stays high with `rsp_rdata` stable until a cycle in which `rsp_ready` is high.
- R3: Control register at debug address 0x38. Writable fields: size in [19:17] (2 = word), read-on-address in bit 20, auto-increment in bit 16, read-on-data in bit 15. Sticky busy-error bit 22 and error code [14:12] are cleared by writing 1s to them. A written value reads back as written when idle and error-free.
- R4: A write to the data register (0x3c) stores the value and starts a bus write of it to the current address. `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` are held stable until `bus_done`, and `bus_valid` drops in the following cycle.
- R5: With auto-increment set, each completed access adds 4 to the address register. Five data writes from address 0 land at 0x0, 0x4, 0x8, 0xC and 0x10.
- R6: A write to the address register (0x39) stores the new address. With read-on-address set, it starts a bus read at that new address, and the read word is stored in the data register.
- R7: With read-on-data set, a read of the data register returns the stored word and then starts a bus read at the current address, so consecutive reads return consecutive words.
- R8: Bit 21 of the control register reads 1 while a bus access is outstanding, including the cycle in which `bus_done` arrives.
- R9: An access to the address or data register while busy sets busy-error. While busy or busy-error is set, such accesses change no register and start no bus access.
- R10: A bus access triggered while the size field is not 2 does not reach the bus. It sets the error code to 4.
- R11: A write to debug address 0x10 with bit 0 clear resets the control fields, address and data to zero. With bit 0 set, the write has no effect.
- R12: With auto-increment clear, the address register is unchanged by completed accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Debug-register request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | DBG_AW (7) | Debug register address |
| req_wdata | input | 32 | Register write value |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Register read value (0 for writes to unread addresses) |
| bus_valid | output | 1 | Memory request outstanding |
| bus_write | output | 1 | 1 = memory write |
| bus_addr | output | ADDR_W (32) | Memory byte address |
| bus_wdata | output | 32 | Memory write data |
| bus_rdata | input | 32 | Memory read data, valid with bus_done |
| bus_done | input | 1 | Memory completes the outstanding request |

## Verification
Two functions can fall in the same cycle: completion of a bus access, and a new data-register write arriving from the host. The bench stalls the memory model with a write outstanding, then releases it so that `bus_done` and the accepted request share one clock edge. The busy state at that edge is still the registered one, so the new write must be refused. That edge must raise busy-error and leave the bus idle afterwards. Memory must keep the first value, with exactly one bus access counted, and the address register must be unchanged.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam logic [6:0] DA_DMCTL = 7'h10;
  localparam logic [6:0] DA_CTRL  = 7'h38;
  localparam logic [6:0] DA_ADDR  = 7'h39;
  localparam logic [6:0] DA_DATA  = 7'h3c;

  localparam logic [2:0] SIZE_WORD = 3'd2;
  localparam logic [2:0] ERR_SIZE  = 3'd4;
  localparam logic [2:0] VERSION   = 3'd1;

  localparam int B_BUSYERR = 22;
  localparam int B_BUSY    = 21;
  localparam int B_RDADDR  = 20;
  localparam int B_SIZE_LO = 17;
  localparam int B_AUTOINC = 16;
  localparam int B_RDDATA  = 15;
  localparam int B_ERR_LO  = 12;

  typedef struct packed {
    logic       busy_err;
    logic       rd_on_addr;
    logic [2:0] size;
    logic       auto_inc;
    logic       rd_on_data;
    logic [2:0] err;
  } ctrl_t;

  function automatic logic [31:0] pack_ctrl(ctrl_t c, logic busy, logic [6:0] aw);
    return {VERSION, 6'b0, c.busy_err, busy, c.rd_on_addr, c.size,
            c.auto_inc, c.rd_on_data, c.err, aw, 5'b00100};
  endfunction
endpackage

// File: rtl/sba_host_port.sv
module sba_host_port #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              accept,
  input  logic [DATA_W-1:0] rdata_now,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rdata_now;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sba_bus_master.sv
module sba_bus_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              busy,
  output logic              fin,
  output logic              fin_we,
  output logic [DATA_W-1:0] fin_rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_done
);
  assign busy      = bus_valid;
  assign fin       = bus_valid && bus_done;
  assign fin_we    = bus_write;
  assign fin_rdata = bus_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (start) begin
      bus_valid <= 1'b1;
      bus_write <= start_we;
      bus_addr  <= start_addr;
      bus_wdata <= start_wdata;
    end else if (fin) begin
      bus_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sba_regs.sv
module sba_regs
  import sba_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DBG_AW = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [DBG_AW-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rdata_now,
  input  logic              busy,
  input  logic              fin,
  input  logic              fin_we,
  input  logic [DATA_W-1:0] fin_rdata,
  output logic              start,
  output logic              start_we,
  output logic [ADDR_W-1:0] start_addr,
  output logic [DATA_W-1:0] start_wdata
);
  localparam logic [6:0] AW_FIELD = 7'(ADDR_W);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  ctrl_t             cr;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  logic hit_ctrl, hit_addr, hit_data, hit_dm;
  logic blocked, trig_waddr, trig_wdata, trig_rdata;
  logic launch_rd, launch_wr, size_ok, dm_clear;

  assign hit_ctrl = req_addr == DBG_AW'(DA_CTRL);
  assign hit_addr = req_addr == DBG_AW'(DA_ADDR);
  assign hit_data = req_addr == DBG_AW'(DA_DATA);
  assign hit_dm   = req_addr == DBG_AW'(DA_DMCTL);

  assign blocked    = busy || cr.busy_err;
  assign trig_waddr = accept && req_write && hit_addr && !blocked;
  assign trig_wdata = accept && req_write && hit_data && !blocked;
  assign trig_rdata = accept && !req_write && hit_data && !blocked;
  assign launch_rd  = (trig_waddr && cr.rd_on_addr) || (trig_rdata && cr.rd_on_data);
  assign launch_wr  = trig_wdata;
  assign size_ok    = cr.size == SIZE_WORD;
  assign dm_clear   = accept && req_write && hit_dm && !req_wdata[0];

  assign start       = (launch_rd || launch_wr) && size_ok;
  assign start_we    = launch_wr;
  assign start_addr  = trig_waddr ? req_wdata[ADDR_W-1:0] : addr_q;
  assign start_wdata = req_wdata;

  always_comb begin
    rdata_now = '0;
    if (hit_ctrl)      rdata_now = pack_ctrl(cr, busy, AW_FIELD);
    else if (hit_addr) rdata_now = DATA_W'(addr_q);
    else if (hit_data) rdata_now = data_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || dm_clear) begin
      cr     <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (accept && req_write && hit_ctrl) begin
        cr.rd_on_addr <= req_wdata[B_RDADDR];
        cr.size       <= req_wdata[B_SIZE_LO+:3];
        cr.auto_inc   <= req_wdata[B_AUTOINC];
        cr.rd_on_data <= req_wdata[B_RDDATA];
        cr.busy_err   <= cr.busy_err & ~req_wdata[B_BUSYERR];
        cr.err        <= cr.err & ~req_wdata[B_ERR_LO+:3];
      end
      if (accept && (hit_addr || hit_data) && busy)
        cr.busy_err <= 1'b1;
      if ((launch_rd || launch_wr) && !size_ok)
        cr.err <= ERR_SIZE;
      if (trig_waddr) addr_q <= req_wdata[ADDR_W-1:0];
      if (trig_wdata) data_q <= req_wdata;
      if (fin) begin
        if (!fin_we)    data_q <= fin_rdata;
        if (cr.auto_inc) addr_q <= addr_q + STEP;
      end
    end
  end
endmodule

// File: rtl/sba_engine.sv
module sba_engine #(
  parameter int ADDR_W = 32,
  parameter int DBG_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DBG_AW-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_done
);
  localparam int DATA_W = 32;

  logic              accept, busy, fin, fin_we, start, start_we;
  logic [DATA_W-1:0] rdata_now, fin_rdata, start_wdata;
  logic [ADDR_W-1:0] start_addr;

  sba_host_port #(.DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .accept(accept), .rdata_now(rdata_now), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  sba_regs #(.ADDR_W(ADDR_W), .DBG_AW(DBG_AW), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rdata_now(rdata_now),
    .busy(busy), .fin(fin), .fin_we(fin_we), .fin_rdata(fin_rdata),
    .start(start), .start_we(start_we), .start_addr(start_addr),
    .start_wdata(start_wdata)
  );

  sba_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(start), .start_we(start_we),
    .start_addr(start_addr), .start_wdata(start_wdata), .busy(busy),
    .fin(fin), .fin_we(fin_we), .fin_rdata(fin_rdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done)
  );
endmodule

// File: rtl/sba_engine_chk.sv
module sba_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_done
);
  // R4: request qualifiers held until memory answers
  p_bus_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_done |=> bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata));

  // R4: request released right after completion
  p_bus_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_done |=> !bus_valid);

  // R2: response held under back-pressure
  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R2: acceptance yields a response next cycle
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R2: no acceptance while a response waits
  p_one_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind sba_engine sba_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_done(bus_done)
);

// File: tb/sba_engine_test.sv
`timescale 1ns/1ps
module sba_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [6:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, bus_valid, bus_write;
  logic [31:0] rsp_rdata, bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_done = 1'b0;

  int n_chk = 0, n_fail = 0;
  int lat = 2, cnt = 0, bus_count = 0;
  bit hold_bus = 1'b0;
  logic [31:0] mem [32];

  always #5 clk = ~clk;

  sba_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done)
  );

  // memory model: answers after lat idle cycles, one-cycle done pulse
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_done = 1'b0; cnt = 0;
    end else if (bus_done) begin
      bus_done = 1'b0;
    end else if (bus_valid && !hold_bus) begin
      if (cnt >= lat) begin
        bus_done = 1'b1; cnt = 0; bus_count++;
        if (bus_write) mem[bus_addr[6:2]] = bus_wdata;
        else bus_rdata = mem[bus_addr[6:2]];
      end else cnt++;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic acc(input bit we, input logic [6:0] a, input logic [31:0] d,
                     input bit wait_idle, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_rdata;
    if (wait_idle) while (bus_valid) @(negedge clk);
  endtask

  typedef struct packed {
    logic        we;
    logic [6:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic        chk;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t VEC [17] = '{
    '{1'b1, 7'h38, 32'h20050404, 32'h0, 1'b0, 4'd3},   // R3 word, auto-increment
    '{1'b0, 7'h38, 32'h0, 32'h20050404, 1'b1, 4'd3},   // R3 read back
    '{1'b1, 7'h39, 32'h0, 32'h0, 1'b0, 4'd6},
    '{1'b1, 7'h3c, 32'hC0DE0000, 32'h0, 1'b0, 4'd4},   // R4 stream writes
    '{1'b1, 7'h3c, 32'hC0DE0001, 32'h0, 1'b0, 4'd4},
    '{1'b1, 7'h3c, 32'hC0DE0002, 32'h0, 1'b0, 4'd4},
    '{1'b1, 7'h3c, 32'hC0DE0003, 32'h0, 1'b0, 4'd4},
    '{1'b1, 7'h3c, 32'hC0DE0004, 32'h0, 1'b0, 4'd4},
    '{1'b0, 7'h39, 32'h0, 32'h14, 1'b1, 4'd5},         // R5 address advanced by 5*4
    '{1'b1, 7'h38, 32'h20158404, 32'h0, 1'b0, 4'd3},   // read-on-address and read-on-data
    '{1'b1, 7'h39, 32'h0, 32'h0, 1'b0, 4'd6},          // R6 read at 0
    '{1'b0, 7'h3c, 32'h0, 32'hC0DE0000, 1'b1, 4'd6},   // R6 word from address write
    '{1'b0, 7'h3c, 32'h0, 32'hC0DE0001, 1'b1, 4'd7},   // R7 streaming reads
    '{1'b0, 7'h3c, 32'h0, 32'hC0DE0002, 1'b1, 4'd7},
    '{1'b0, 7'h3c, 32'h0, 32'hC0DE0003, 1'b1, 4'd7},
    '{1'b0, 7'h3c, 32'h0, 32'hC0DE0004, 1'b1, 4'd7},
    '{1'b0, 7'h39, 32'h0, 32'h18, 1'b1, 4'd5}          // R5 after six reads
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r, hold_val;
    int bc;
    for (int i = 0; i < 32; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 ready", {31'b0, req_ready}, 32'h1);
    chk("R1 bus idle", {31'b0, bus_valid}, 32'h0);
    acc(1'b0, 7'h38, 0, 1'b1, r); chk("R1 ctrl", r, 32'h20000404);
    acc(1'b0, 7'h39, 0, 1'b1, r); chk("R1 addr", r, 32'h0);
    acc(1'b0, 7'h3c, 0, 1'b1, r); chk("R1 data", r, 32'h0);

    // vector walk
    foreach (VEC[k]) begin
      acc(VEC[k].we, VEC[k].a, VEC[k].d, 1'b1, r);
      if (VEC[k].chk) chk($sformatf("R%0d vec%0d", VEC[k].rq, k), r, VEC[k].exp);
    end
    for (int j = 0; j < 5; j++)
      chk($sformatf("R5 landing %0d", j), mem[j], 32'hC0DE0000 + j);

    // R12 no increment
    acc(1'b1, 7'h38, 32'h20040404, 1'b1, r);
    acc(1'b1, 7'h39, 32'h20, 1'b1, r);
    acc(1'b1, 7'h3c, 32'h55, 1'b1, r);
    chk("R12 mem", mem[8], 32'h55);
    acc(1'b0, 7'h39, 0, 1'b1, r); chk("R12 addr", r, 32'h20);

    // R10 bad size
    acc(1'b1, 7'h38, 32'h20020404, 1'b1, r);
    bc = bus_count;
    acc(1'b1, 7'h3c, 32'h66, 1'b1, r);
    repeat (4) @(negedge clk);
    chk("R10 no bus", bus_count, bc);
    acc(1'b0, 7'h38, 0, 1'b1, r); chk("R10 err code", r, 32'h20024404);
    acc(1'b1, 7'h38, 32'h20047404, 1'b1, r);
    acc(1'b0, 7'h38, 0, 1'b1, r); chk("R3 err w1c", r, 32'h20040404);

    // R8 / R9 busy and done-cycle collision
    hold_bus = 1'b1; lat = 0;
    acc(1'b1, 7'h39, 32'h30, 1'b1, r);
    bc = bus_count;
    acc(1'b1, 7'h3c, 32'h77, 1'b0, r);
    acc(1'b0, 7'h38, 0, 1'b0, r); chk("R8 busy", r, 32'h20240404);
    acc(1'b1, 7'h39, 32'h0, 1'b0, r);
    @(posedge clk); #1 hold_bus = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 7'h3c; req_wdata = 32'h99;
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 bus idle", {31'b0, bus_valid}, 32'h0);
    chk("R9 one access", bus_count, bc + 1);
    chk("R4 mem kept", mem[12], 32'h77);
    acc(1'b0, 7'h38, 0, 1'b1, r); chk("R9 busy error", r, 32'h20440404);
    acc(1'b0, 7'h39, 0, 1'b1, r); chk("R9 addr kept", r, 32'h30);
    bc = bus_count;
    acc(1'b1, 7'h3c, 32'h11, 1'b1, r);
    repeat (3) @(negedge clk);
    chk("R9 blocked", bus_count, bc);
    acc(1'b1, 7'h38, 32'h20440404, 1'b1, r);
    acc(1'b0, 7'h38, 0, 1'b1, r); chk("R9 w1c", r, 32'h20040404);

    // R2 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 7'h39;
    @(negedge clk); req_valid = 1'b0; hold_val = rsp_rdata;
    repeat (3) @(negedge clk);
    chk("R2 held valid", {30'b0, rsp_valid, req_ready}, 32'h2);
    chk("R2 held data", rsp_rdata, hold_val);
    chk("R2 data value", hold_val, 32'h30);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R2 released", {31'b0, rsp_valid}, 32'h0);

    // R11 debug-module clear
    acc(1'b1, 7'h10, 32'h1, 1'b1, r);
    acc(1'b0, 7'h38, 0, 1'b1, r); chk("R11 active kept", r, 32'h20040404);
    acc(1'b1, 7'h10, 32'h0, 1'b1, r);
    acc(1'b0, 7'h38, 0, 1'b1, r); chk("R11 ctrl", r, 32'h20000404);
    acc(1'b0, 7'h39, 0, 1'b1, r); chk("R11 addr", r, 32'h0);
    acc(1'b0, 7'h3c, 0, 1'b1, r); chk("R11 data", r, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule